// File: doc/BRIEF.md
# Nine-Bit Multicycle Register Processor Core

This core runs a small instruction set over one shared internal bus, taking several clock steps per instruction. It has eight general registers. The last of them, R7, is also the program counter: the control logic can step it forward by one, or load it from the bus like any other register. Instructions and data come from a synchronous external memory that returns a word one cycle after it sees an address. The core drives that memory's address, write-data and write-enable lines and reads its data-in line.

Seven instructions are supported: register move, move-immediate, add, subtract, load from memory, store to memory, and a move that takes effect only when the G result register is nonzero. If a move or move-immediate names R7 as its destination, the instruction acts as a jump. Reading R7 as a source gives the address of the next instruction. Together these let software build loops, such as a count-down delay that branches back with the conditional move. A one-cycle `done` strobe marks the last step of every instruction.

Top module: `mcpu_core`

## Requirements
- R1: While `rst` is high, all eight registers, IR, A and G clear to 0 and `done` is low. In the first cycle after `rst` falls, the core fetches from `mem_addr` = 0.
- R2: An instruction word holds the opcode in bits [8:6], Rx in [5:3] and Ry in [2:0]. The opcodes are mv=000, mvi=001, add=010, sub=011, ld=100, st=101, mvnz=110. In the fetch step, the PC is driven on `mem_addr`. The word returned in the next cycle goes into IR, and the PC advances by one.
- R3: mvi Rx takes its immediate from the word after the opcode. The PC advances a second time, and execution continues after the immediate.
- R4: A mv or mvi with Rx = R7 loads the PC, and the next fetch comes from the loaded address. A taken mvnz R7,Ry also jumps.
- R5: mv Rx,R7 writes into Rx the address of the instruction that follows the mv.
- R6: add and sub take three execute steps: A←Rx, then G←A±Ry modulo 2^9, then Rx←G. G changes only in the middle step.
- R7: ld Rx,[Ry] drives Ry on `mem_addr`, waits one cycle, then writes the returned word into Rx.
- R8: st Rx,[Ry] drives Ry on `mem_addr` and Rx on `mem_wdata`, with `mem_we` high for exactly one cycle.
- R9: mvnz Rx,Ry copies Ry into Rx only when G is nonzero. When G is zero it changes nothing.
- R10: `done` is high in the final step of each instruction, and a fetch follows it. Cycle counts per instruction are: mv, st and mvnz take 3; mvi and ld take 4; add and sub take 5.
- R11: The unused opcode 111 is a no-op. It ends in its IR-capture step, which is its second cycle, with `done` high there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_rdata | input | 9 | Word returned by memory, one cycle after the address |
| mem_addr | output | 9 | Memory address (value on the internal bus) |
| mem_wdata | output | 9 | Store data (register Rx) |
| mem_we | output | 1 | Memory write strobe |
| done | output | 1 | High in the last step of each instruction |

## Verification
The checker watches several rules on every clock edge. It checks that every fetch step and every immediate-address step advance the PC by exactly one, and that G holds its value outside the ALU result step. It also checks that the write strobe never lasts two cycles, that a fetch always follows `done`, and that the first cycle after reset fetches from address 0. Other behaviours can only be seen in running programs, so the bench shows them with full scenarios. These include arithmetic wraparound, conditional-move outcomes, jumps through R7, the load data path and the exact cycle of each store. The bench also runs a count-down delay loop for several trip counts, including the 512-pass wrap that results from a start value of zero.

// File: rtl/mcpu_pkg.sv
`timescale 1ns/1ps
package mcpu_pkg;

    localparam int FW     = 3;
    localparam int OP_LSB = 6;
    localparam int RX_LSB = 3;
    localparam int RY_LSB = 0;
    localparam int NREG   = 1 << FW;

    typedef enum logic [FW-1:0] {
        OP_MV   = 3'b000,
        OP_MVI  = 3'b001,
        OP_ADD  = 3'b010,
        OP_SUB  = 3'b011,
        OP_LD   = 3'b100,
        OP_ST   = 3'b101,
        OP_MVNZ = 3'b110,
        OP_RSV  = 3'b111
    } op_e;

    typedef enum logic [3:0] {
        S_FETCH,
        S_IRLD,
        S_MV,
        S_MVI_ADDR,
        S_MVI_DATA,
        S_ALU_A,
        S_ALU_G,
        S_ALU_WB,
        S_LD_ADDR,
        S_LD_DATA,
        S_ST,
        S_MVNZ
    } state_e;

    typedef enum logic [1:0] {
        BUS_REG,
        BUS_G,
        BUS_DIN
    } bsrc_e;

    typedef struct packed {
        bsrc_e          bsrc;
        logic [FW-1:0]  bsel;
        logic           wr_en;
        logic           ir_ld;
        logic           a_ld;
        logic           g_ld;
        logic           alu_sub;
        logic           pc_inc;
        logic           we;
        logic           done;
    } ctl_t;

endpackage

// File: rtl/mcpu_regfile.sv
`timescale 1ns/1ps
module mcpu_regfile #(
    parameter int DW   = 9,
    parameter int NREG = 8,
    localparam int SW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          pc_inc,
    input  logic [SW-1:0] ra_sel,
    output logic [DW-1:0] ra_data,
    input  logic [SW-1:0] rb_sel,
    output logic [DW-1:0] rb_data,
    output logic [DW-1:0] pc
);

    logic [DW-1:0] regs [NREG];

    generate
        for (genvar i = 0; i < NREG; i++) begin : g_reg
            logic [DW-1:0] q;
            logic          hit;
            assign hit = wr_en && (wr_sel == SW'(i));
            if (i == NREG - 1) begin : g_pc
                // last register: parallel load wins over increment
                always_ff @(posedge clk) begin
                    if (rst)         q <= '0;
                    else if (hit)    q <= wr_data;
                    else if (pc_inc) q <= q + DW'(1);
                end
            end else begin : g_gp
                always_ff @(posedge clk) begin
                    if (rst)      q <= '0;
                    else if (hit) q <= wr_data;
                end
            end
            assign regs[i] = q;
        end
    endgenerate

    assign ra_data = regs[ra_sel];
    assign rb_data = regs[rb_sel];
    assign pc      = regs[NREG-1];

endmodule

// File: rtl/mcpu_alu.sv
`timescale 1ns/1ps
module mcpu_alu #(
    parameter int DW = 9
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          sub,
    output logic [DW-1:0] y
);

    assign y = sub ? (a - b) : (a + b);

endmodule

// File: rtl/mcpu_ctrl.sv
`timescale 1ns/1ps
module mcpu_ctrl
    import mcpu_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  op_e            din_op,
    input  op_e            ir_op,
    input  logic [FW-1:0]  ir_rx,
    input  logic [FW-1:0]  ir_ry,
    input  logic           g_nz,
    output state_e         st,
    output ctl_t           ctl
);

    localparam logic [FW-1:0] PC_IDX = FW'(NREG - 1);

    state_e nx;

    always_ff @(posedge clk) begin
        if (rst) st <= S_FETCH;
        else     st <= nx;
    end

    always_comb begin
        nx = S_FETCH;
        unique case (st)
            S_FETCH:    nx = S_IRLD;
            S_IRLD: begin
                unique case (din_op)
                    OP_MV:          nx = S_MV;
                    OP_MVI:         nx = S_MVI_ADDR;
                    OP_ADD, OP_SUB: nx = S_ALU_A;
                    OP_LD:          nx = S_LD_ADDR;
                    OP_ST:          nx = S_ST;
                    OP_MVNZ:        nx = S_MVNZ;
                    default:        nx = S_FETCH;
                endcase
            end
            S_MVI_ADDR: nx = S_MVI_DATA;
            S_ALU_A:    nx = S_ALU_G;
            S_ALU_G:    nx = S_ALU_WB;
            S_LD_ADDR:  nx = S_LD_DATA;
            default:    nx = S_FETCH;
        endcase
    end

    always_comb begin
        ctl      = '0;
        ctl.bsrc = BUS_REG;
        ctl.bsel = ir_ry;
        unique case (st)
            S_FETCH: begin
                ctl.bsel   = PC_IDX;
                ctl.pc_inc = 1'b1;
            end
            S_IRLD: begin
                ctl.ir_ld = 1'b1;
                ctl.done  = (din_op == OP_RSV);
            end
            S_MV: begin
                ctl.wr_en = 1'b1;
                ctl.done  = 1'b1;
            end
            S_MVI_ADDR: begin
                ctl.bsel   = PC_IDX;
                ctl.pc_inc = 1'b1;
            end
            S_MVI_DATA, S_LD_DATA: begin
                ctl.bsrc  = BUS_DIN;
                ctl.wr_en = 1'b1;
                ctl.done  = 1'b1;
            end
            S_ALU_A: begin
                ctl.bsel = ir_rx;
                ctl.a_ld = 1'b1;
            end
            S_ALU_G: begin
                ctl.g_ld    = 1'b1;
                ctl.alu_sub = (ir_op == OP_SUB);
            end
            S_ALU_WB: begin
                ctl.bsrc  = BUS_G;
                ctl.wr_en = 1'b1;
                ctl.done  = 1'b1;
            end
            S_LD_ADDR: ;
            S_ST: begin
                ctl.we   = 1'b1;
                ctl.done = 1'b1;
            end
            S_MVNZ: begin
                ctl.wr_en = g_nz;
                ctl.done  = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/mcpu_core.sv
`timescale 1ns/1ps
module mcpu_core
    import mcpu_pkg::*;
#(
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    output logic          done
);

    state_e        st;
    ctl_t          ctl;
    logic [DW-1:0] ir_q, a_q, g_q, bus, ra_data, pc, alu_y;
    op_e           ir_op, din_op;
    logic [FW-1:0] ir_rx, ir_ry;

    assign ir_op  = op_e'(ir_q[OP_LSB +: FW]);
    assign ir_rx  = ir_q[RX_LSB +: FW];
    assign ir_ry  = ir_q[RY_LSB +: FW];
    assign din_op = op_e'(mem_rdata[OP_LSB +: FW]);

    mcpu_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .din_op (din_op),
        .ir_op  (ir_op),
        .ir_rx  (ir_rx),
        .ir_ry  (ir_ry),
        .g_nz   (|g_q),
        .st     (st),
        .ctl    (ctl)
    );

    mcpu_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ctl.wr_en),
        .wr_sel  (ir_rx),
        .wr_data (bus),
        .pc_inc  (ctl.pc_inc),
        .ra_sel  (ctl.bsel),
        .ra_data (ra_data),
        .rb_sel  (ir_rx),
        .rb_data (mem_wdata),
        .pc      (pc)
    );

    mcpu_alu #(.DW(DW)) u_alu (
        .a   (a_q),
        .b   (bus),
        .sub (ctl.alu_sub),
        .y   (alu_y)
    );

    always_comb begin
        unique case (ctl.bsrc)
            BUS_REG: bus = ra_data;
            BUS_G:   bus = g_q;
            BUS_DIN: bus = mem_rdata;
            default: bus = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ir_q <= '0;
            a_q  <= '0;
            g_q  <= '0;
        end else begin
            if (ctl.ir_ld) ir_q <= mem_rdata;
            if (ctl.a_ld)  a_q  <= bus;
            if (ctl.g_ld)  g_q  <= alu_y;
        end
    end

    assign mem_addr = bus;
    assign mem_we   = ctl.we;
    assign done     = ctl.done;

endmodule

// File: rtl/mcpu_core_chk.sv
`timescale 1ns/1ps
module mcpu_core_chk
    import mcpu_pkg::*;
#(
    parameter int DW = 9
) (
    input logic          clk,
    input logic          rst,
    input state_e        state,
    input logic [DW-1:0] pc,
    input logic [DW-1:0] g,
    input logic [DW-1:0] mem_addr,
    input logic          mem_we,
    input logic          done
);

    a_r1_first_fetch: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (state == S_FETCH && mem_addr == '0));

    a_r2_fetch_step: assert property (@(posedge clk) disable iff (rst)
        (state == S_FETCH) |=> (pc == $past(pc) + DW'(1)));

    a_r3_imm_skip: assert property (@(posedge clk) disable iff (rst)
        (state == S_MVI_ADDR) |=> (pc == $past(pc) + DW'(1)));

    a_r6_g_hold: assert property (@(posedge clk) disable iff (rst)
        (state != S_ALU_G) |=> $stable(g));

    a_r8_we_pulse: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    a_r10_done_refetch: assert property (@(posedge clk) disable iff (rst)
        done |=> (state == S_FETCH));

endmodule

bind mcpu_core mcpu_core_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .state    (st),
    .pc       (pc),
    .g        (g_q),
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .done     (done)
);

// File: tb/sim_mcpu_core.sv
`timescale 1ns/1ps
module sim_mcpu_core;

    localparam int DW = 9;
    localparam int MD = 1 << DW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [DW-1:0] mem_rdata = '0;
    logic [DW-1:0] mem_addr, mem_wdata;
    logic          mem_we, done;

    mcpu_core #(.DW(DW)) u0 (
        .clk       (clk),
        .rst       (rst),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .done      (done)
    );

    logic [DW-1:0] mem  [MD];
    logic [DW-1:0] wlog [MD];
    int            wcyc [MD];
    int            nwr, cyc;
    logic          clr = 1'b0, ld_en = 1'b0;
    logic [DW-1:0] ld_a = '0, ld_d = '0;

    // memory model: one cycle read latency, write log with cycle stamp
    always @(posedge clk) begin
        if (clr) begin
            for (int i = 0; i < MD; i++) begin
                mem[i]  <= '0;
                wlog[i] <= '0;
                wcyc[i] <= -1;
            end
            nwr <= 0;
            cyc <= 0;
        end else if (ld_en) begin
            mem[ld_a] <= ld_d;
        end else if (rst) begin
            cyc <= 0;
        end else begin
            if (mem_we) begin
                mem[mem_addr]  <= mem_wdata;
                wlog[mem_addr] <= mem_wdata;
                wcyc[mem_addr] <= cyc;
                nwr            <= nwr + 1;
            end
            mem_rdata <= mem[mem_addr];
            cyc       <= cyc + 1;
        end
    end

    int ncmp = 0;
    int nbad = 0;

    task automatic chk(input string tag, input int act, input int exp);
        ncmp++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int enc(input int op, input int x, input int y);
        return op * 64 + x * 8 + y;
    endfunction

    task automatic begin_prog();
        rst = 1'b1;
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic put(input int a, input int d);
        ld_en = 1'b1;
        ld_a  = DW'(a);
        ld_d  = DW'(d);
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic run(input int n);
        rst = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
        $finish;
    endtask

    initial begin
        #1_500_000;
        nbad++;
        $display("FAIL R10 watchdog: actual %0d expected %0d", cyc, 0);
        summary();
    end

    initial begin
        int vals [7] = '{0, 1, 2, 255, 256, 510, 511};

        // ---- reset state, reserved opcode, cleared registers (R1, R11) ----
        begin_prog();
        put(0, 9'b111_000_000);
        put(1, enc(1, 1, 0)); put(2, 7);
        put(3, enc(1, 0, 0)); put(4, 210);
        put(5, enc(5, 1, 0));
        put(6, enc(1, 0, 0)); put(7, 211);
        put(8, enc(5, 3, 0));
        put(9, enc(1, 7, 0)); put(10, 9);
        chk("R1 done low in reset", int'(done), 0);
        rst = 1'b0;
        #1;
        chk("R1 first fetch address", int'(mem_addr), 0);
        chk("R1 no write after reset", int'(mem_we), 0);
        chk("R1 done low first cycle", int'(done), 0);
        @(negedge clk); #1;
        chk("R11 reserved opcode done in cycle 1", int'(done), 1);
        repeat (30) @(negedge clk);
        chk("R11 mvi after no-op value", int'(wlog[210]), 7);
        chk("R11 store cycle after no-op", wcyc[210], 12);
        chk("R1 untouched register reads 0", int'(wlog[211]), 0);
        chk("R8 store cycle", wcyc[211], 19);
        chk("R8 write count", nwr, 2);

        // ---- ALU / ld / st / mvnz sweep (R2 R3 R6 R7 R8 R9 R10) ----
        foreach (vals[ia]) begin
            foreach (vals[ib]) begin
                int a = vals[ia];
                int b = vals[ib];
                int dif = (a - b) & (MD - 1);
                begin_prog();
                put(0, enc(1, 1, 0)); put(1, a);
                put(2, enc(1, 2, 0)); put(3, b);
                put(4, enc(0, 3, 1));
                put(5, enc(2, 3, 2));
                put(6, enc(1, 0, 0)); put(7, 200);
                put(8, enc(5, 3, 0));
                put(9, enc(3, 1, 2));
                put(10, enc(1, 0, 0)); put(11, 201);
                put(12, enc(5, 1, 0));
                put(13, enc(4, 6, 0));
                put(14, enc(1, 0, 0)); put(15, 202);
                put(16, enc(5, 6, 0));
                put(17, enc(6, 5, 2));
                put(18, enc(1, 0, 0)); put(19, 203);
                put(20, enc(5, 5, 0));
                put(21, enc(1, 7, 0)); put(22, 21);
                run(70);
                chk("R6 add wraps mod 512", int'(wlog[200]), (a + b) & (MD - 1));
                chk("R10 add+mvi+mv+st timing", wcyc[200], 22);
                chk("R6 sub wraps mod 512", int'(wlog[201]), dif);
                chk("R10 sub timing", wcyc[201], 34);
                chk("R7 load returns stored word", int'(wlog[202]), dif);
                chk("R7 load timing", wcyc[202], 45);
                chk("R9 mvnz outcome", int'(wlog[203]), (dif != 0) ? b : 0);
                chk("R10 mvnz timing", wcyc[203], 55);
                chk("R8 one write per store", nwr, 4);
            end
        end

        // ---- delay loop via R7 jumps (R3 R4 R5 R9 R10) ----
        foreach (vals[k]) begin
            int n = (k < 4) ? k + 1 : ((k == 4) ? 9 : ((k == 5) ? 17 : 0));
            int p = (n == 0) ? MD : n;
            begin_prog();
            put(0, enc(1, 2, 0)); put(1, 1);
            put(2, enc(1, 4, 0)); put(3, n);
            put(4, enc(0, 5, 7));
            put(5, enc(3, 4, 2));
            put(6, enc(6, 7, 5));
            put(7, enc(1, 6, 0)); put(8, 100);
            put(9, enc(5, 4, 6));
            put(10, enc(1, 6, 0)); put(11, 101);
            put(12, enc(5, 5, 6));
            put(13, enc(1, 7, 0)); put(14, 13);
            run(40 + 8 * p);
            chk("R4 loop counter reaches 0", int'(wlog[100]), 0);
            chk("R4 exact pass count via store cycle", wcyc[100], 17 + 8 * p);
            chk("R5 mv from R7 gives next address", int'(wlog[101]), 5);
            chk("R4 fall-through then halt jump", wcyc[101], 24 + 8 * p);
            chk("R3 no stray writes", nwr, 2);
        end

        summary();
    end

endmodule